// File: doc/BRIEF.md
# Smart Card Receive Waiting-Time Watchdog

This block watches how long the interface waits for characters coming from a smart card. Two 16-bit timers count in elementary time units (etus), using a tick from a shared etu prescaler. The block-wait timer starts when a new receive block opens and limits the delay until the card's first start bit. When that first start bit arrives, the block-wait timer stops. The character-wait timer then takes over and limits the gap between each later character. Every detected start-bit leading edge reloads the character-wait timer.

The two timers run in sequence. The character-wait timer only runs once the block-wait timer has stopped. The block-wait timer stops either because a character arrived or because it is disabled. Neither timer advances while the transmitter still has characters queued. When a timer reaches its programmed limit, the block emits a one-cycle timeout pulse and goes idle until the next block-start request. Software or a protocol engine computes the limits from the card's answer-to-reset parameters. Examples: 971 to 15371 etus for a block wait, 12 to 43 etus for a character gap, and 9600 etus for a character-protocol work wait.

Top module: `sc_wait_watchdog`

## Requirements
- R1: After reset both timeout outputs are low, and the block stays idle. Etu ticks and start bits produce no pulse until `blk_start` is seen.
- R2: A `blk_start` pulse with `blk_en` high clears and starts the block-wait timer. `blk_timeout` is high for one cycle, right after the clock edge that samples the `blk_limit`-th counted etu tick, unless a start bit came first.
- R3: A `start_bit` pulse while the block-wait timer runs stops it for good and starts the character-wait timer from zero.
- R4: While the character-wait timer runs, each `start_bit` reloads it to zero. `chr_timeout` pulses for one cycle right after the edge that samples the `chr_limit`-th counted tick since the most recent reload.
- R5: A tick sampled while `tx_busy` is high is not counted by either timer.
- R6: If `blk_en` is low at `blk_start`, or goes low while the block-wait timer runs, the block-wait timer is skipped or stopped. The character-wait timer then starts from zero, and no `blk_timeout` is produced.
- R7: While `chr_en` is low the character-wait timer holds its count and emits no `chr_timeout`. Counting resumes when `chr_en` returns high.
- R8: After either timeout, both timers stay stopped. Ticks and start bits cause no pulse until the next `blk_start`.
- R9: A limit of 0 behaves as a limit of 1.
- R10: In a single cycle, `blk_start` has priority over `start_bit`, and `start_bit` has priority over a tick. A tick that coincides with either of them is not counted.
- R11: Each timeout pulse lasts one cycle, and the two timeouts are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per etu from the shared prescaler |
| blk_start | input | 1 | Opens a new receive block and restarts the sequence |
| start_bit | input | 1 | Receiver's start-bit leading-edge detect pulse |
| tx_busy | input | 1 | Transmit queue not yet empty; freezes both timers |
| blk_en | input | 1 | Enables the block-wait timer |
| chr_en | input | 1 | Enables the character-wait timer |
| blk_limit | input | 16 | Block-wait limit in etus |
| chr_limit | input | 16 | Character-wait limit in etus |
| blk_timeout | output | 1 | One-cycle block-wait timeout pulse |
| chr_timeout | output | 1 | One-cycle character-wait timeout pulse |

## Verification
Each timeout is registered, so it appears right after the same clock edge that samples the deciding tick. It never comes later. A `blk_start` or `start_bit` changes the timer state at that same edge.

The bench drives its inputs shortly after a rising edge. It updates a behavioural model at every rising edge and compares both outputs at the following falling edge. The model and the design therefore always refer to the same sampled inputs.

Directed scenarios also count the pulses seen over a window of ticks. Each window ends two falling edges after its last tick, so the final pulse is always included in the count.

// File: rtl/sc_wait_pkg.sv
package sc_wait_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BLK  = 2'd1,
      PH_CHR  = 2'd2
   } wait_phase_t;
endpackage

// File: rtl/sc_wait_counter.sv
module sc_wait_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   localparam int SUM_W = CNT_W + 1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("sc_wait_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic [SUM_W-1:0] next_val;
   logic [SUM_W-1:0] eff_limit;

   assign next_val  = {1'b0, count_q} + SUM_W'(1);
   assign eff_limit = (limit == '0) ? SUM_W'(1) : {1'b0, limit};
   assign hit       = step && (next_val >= eff_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (step) begin
         count_q <= next_val[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/sc_wait_seq.sv
module sc_wait_seq
   import sc_wait_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        etu_tick,
   input  logic        blk_start,
   input  logic        start_bit,
   input  logic        tx_busy,
   input  logic        blk_en,
   input  logic        chr_en,
   input  logic        blk_hit,
   input  logic        chr_hit,
   output logic        blk_clear,
   output logic        blk_step,
   output logic        chr_clear,
   output logic        chr_step
);
   wait_phase_t phase_q, phase_d;
   logic        tick_ok;
   logic        leave_blk;

   assign tick_ok   = etu_tick && !tx_busy && !blk_start && !start_bit;
   assign leave_blk = (phase_q == PH_BLK) && (!blk_en || start_bit) && !blk_start;

   assign blk_clear = blk_start;
   assign blk_step  = (phase_q == PH_BLK) && blk_en && tick_ok;
   assign chr_clear = blk_start || leave_blk || ((phase_q == PH_CHR) && start_bit);
   assign chr_step  = (phase_q == PH_CHR) && chr_en && tick_ok;

   always_comb begin
      phase_d = phase_q;
      if (blk_start) begin
         phase_d = blk_en ? PH_BLK : PH_CHR;
      end else if (leave_blk) begin
         phase_d = PH_CHR;
      end else if (blk_hit || chr_hit) begin
         phase_d = PH_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else begin
         phase_q <= phase_d;
      end
   end
endmodule

// File: rtl/sc_wait_watchdog.sv
module sc_wait_watchdog #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             etu_tick,
   input  logic             blk_start,
   input  logic             start_bit,
   input  logic             tx_busy,
   input  logic             blk_en,
   input  logic             chr_en,
   input  logic [CNT_W-1:0] blk_limit,
   input  logic [CNT_W-1:0] chr_limit,
   output logic             blk_timeout,
   output logic             chr_timeout
);
   logic blk_clear, blk_step, blk_hit;
   logic chr_clear, chr_step, chr_hit;

   sc_wait_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .etu_tick  (etu_tick),
      .blk_start (blk_start),
      .start_bit (start_bit),
      .tx_busy   (tx_busy),
      .blk_en    (blk_en),
      .chr_en    (chr_en),
      .blk_hit   (blk_hit),
      .chr_hit   (chr_hit),
      .blk_clear (blk_clear),
      .blk_step  (blk_step),
      .chr_clear (chr_clear),
      .chr_step  (chr_step)
   );

   sc_wait_counter #(.CNT_W(CNT_W)) u_blk_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (blk_clear),
      .step  (blk_step),
      .limit (blk_limit),
      .hit   (blk_hit)
   );

   sc_wait_counter #(.CNT_W(CNT_W)) u_chr_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (chr_clear),
      .step  (chr_step),
      .limit (chr_limit),
      .hit   (chr_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_timeout <= 1'b0;
         chr_timeout <= 1'b0;
      end else begin
         blk_timeout <= blk_hit;
         chr_timeout <= chr_hit;
      end
   end
endmodule

// File: rtl/sc_wait_watchdog_chk.sv
module sc_wait_watchdog_chk (
   input logic clk,
   input logic rst_n,
   input logic etu_tick,
   input logic blk_start,
   input logic start_bit,
   input logic tx_busy,
   input logic blk_en,
   input logic chr_en,
   input logic blk_timeout,
   input logic chr_timeout
);
   // R11
   blk_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_timeout |=> !blk_timeout);
   // R11
   chr_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_timeout |=> !chr_timeout);
   // R11
   no_dual_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(blk_timeout && chr_timeout));
   // R5
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_timeout || chr_timeout) |-> $past(etu_tick && !tx_busy));
   // R10
   tick_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_timeout || chr_timeout) |-> $past(!blk_start && !start_bit));
   // R6
   blk_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_timeout |-> $past(blk_en));
   // R7
   chr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_timeout |-> $past(chr_en));
endmodule

bind sc_wait_watchdog sc_wait_watchdog_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .etu_tick    (etu_tick),
   .blk_start   (blk_start),
   .start_bit   (start_bit),
   .tx_busy     (tx_busy),
   .blk_en      (blk_en),
   .chr_en      (chr_en),
   .blk_timeout (blk_timeout),
   .chr_timeout (chr_timeout)
);

// File: tb/sc_wait_watchdog_test.sv
module sc_wait_watchdog_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        etu_tick = 1'b0, blk_start = 1'b0, start_bit = 1'b0, tx_busy = 1'b0;
   logic        blk_en = 1'b1, chr_en = 1'b1;
   logic [15:0] blk_limit = 16'd4, chr_limit = 16'd3;
   logic        blk_timeout, chr_timeout;

   int checks = 0, fails = 0;
   int nb = 0, nc = 0;
   int mphase = 0, mb = 0, mc = 0;
   bit eb = 0, ec = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sc_wait_watchdog uut (
      .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .blk_start(blk_start),
      .start_bit(start_bit), .tx_busy(tx_busy), .blk_en(blk_en), .chr_en(chr_en),
      .blk_limit(blk_limit), .chr_limit(chr_limit),
      .blk_timeout(blk_timeout), .chr_timeout(chr_timeout)
   );

   function automatic int eff(input int lim);
      return (lim == 0) ? 1 : lim;
   endfunction

   // Behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         mphase = 0; mb = 0; mc = 0; eb = 0; ec = 0;
      end else begin
         eb = 0; ec = 0;
         if (blk_start) begin
            mc = 0;
            if (blk_en) begin mphase = 1; mb = 0; end
            else mphase = 2;
         end else if (mphase == 1) begin
            if (!blk_en || start_bit) begin mphase = 2; mc = 0; end
            else if (etu_tick && !tx_busy) begin
               mb++;
               if (mb >= eff(int'(blk_limit))) begin eb = 1; mphase = 0; end
            end
         end else if (mphase == 2) begin
            if (start_bit) mc = 0;
            else if (etu_tick && !tx_busy && chr_en) begin
               mc++;
               if (mc >= eff(int'(chr_limit))) begin ec = 1; mphase = 0; end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (blk_timeout !== eb) begin
            fails++;
            $display("FAIL R2 blk_timeout actual=%0b expected=%0b at %0t", blk_timeout, eb, $time);
         end
         checks++;
         if (chr_timeout !== ec) begin
            fails++;
            $display("FAIL R4 chr_timeout actual=%0b expected=%0b at %0t", chr_timeout, ec, $time);
         end
         if (blk_timeout) nb++;
         if (chr_timeout) nc++;
      end
   end

   task automatic cyc(input bit bs, input bit sb, input bit tk);
      @(posedge clk); #2;
      blk_start = bs; start_bit = sb; etu_tick = tk;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, 0, 1);
         cyc(0, 0, 0);
      end
   endtask

   task automatic settle();
      cyc(0, 0, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic expect_counts(input string tag, input int eb_n, input int ec_n);
      checks++;
      if (nb != eb_n || nc != ec_n) begin
         fails++;
         $display("FAIL %s pulses blk/chr actual=%0d/%0d expected=%0d/%0d", tag, nb, nc, eb_n, ec_n);
      end
      nb = 0; nc = 0;
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state and idle behaviour
      @(negedge clk);
      checks++;
      if (blk_timeout !== 1'b0 || chr_timeout !== 1'b0) begin
         fails++;
         $display("FAIL R1 outputs actual=%0b%0b expected=00", blk_timeout, chr_timeout);
      end
      ticks(6); cyc(0, 1, 0); ticks(4); settle();
      expect_counts("R1", 0, 0);

      // R2: block timeout after 4 counted ticks
      cyc(1, 0, 0); ticks(3); settle();
      expect_counts("R2 early", 0, 0);
      ticks(1); settle();
      expect_counts("R2", 1, 0);

      // R3/R4: first char stops block timer, later chars reload
      cyc(1, 0, 0); ticks(3); cyc(0, 1, 0);
      ticks(2); cyc(0, 1, 0); ticks(2); cyc(0, 1, 0); ticks(2); settle();
      expect_counts("R3 R4 reload", 0, 0);
      ticks(1); settle();
      expect_counts("R4", 0, 1);

      // R5: transmit pending freezes counting
      tx_busy = 1'b1; cyc(1, 0, 0); ticks(10); settle();
      expect_counts("R5 busy", 0, 0);
      tx_busy = 1'b0; ticks(4); settle();
      expect_counts("R5", 1, 0);

      // R6: block timer disabled at block start
      blk_en = 1'b0; cyc(1, 0, 0); ticks(3); settle();
      expect_counts("R6", 0, 1);
      // R6: block timer disabled mid-phase
      blk_en = 1'b1; cyc(1, 0, 0); ticks(2); blk_en = 1'b0; ticks(3); settle();
      expect_counts("R6 midway", 0, 1);
      blk_en = 1'b1;

      // R7: character timer hold
      chr_en = 1'b0; cyc(1, 0, 0); cyc(0, 1, 0); ticks(10); settle();
      expect_counts("R7 hold", 0, 0);
      chr_en = 1'b1; ticks(3); settle();
      expect_counts("R7", 0, 1);

      // R8: stopped after timeout
      cyc(0, 1, 0); ticks(10); settle();
      expect_counts("R8", 0, 0);

      // R9: zero limit behaves as one
      blk_limit = 16'd0; cyc(1, 0, 0); ticks(1); settle();
      expect_counts("R9", 1, 0);
      blk_limit = 16'd4;

      // R10: same-cycle priority
      cyc(1, 1, 1); cyc(0, 1, 1); ticks(2); settle();
      expect_counts("R10 early", 0, 0);
      ticks(1); settle();
      expect_counts("R10", 0, 1);

      // R11: larger limits, single-width pulses counted by model compare
      blk_limit = 16'd7; chr_limit = 16'd5;
      cyc(1, 0, 0); ticks(7); settle();
      cyc(1, 0, 0); cyc(0, 1, 0); ticks(5); settle();
      expect_counts("R11", 1, 1);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule